// File: doc/BRIEF.md
# Card slot contact sequencer

This block drives the contact enables of a smart-card slot through the power-up and power-down orderings that ISO 7816 cards expect. It runs from the internal oscillator. All its timing is counted in half-steps of 32 oscillator cycles, so one full step T is 64 cycles. A host requests a session by pulling an active-low power command low. The block then brings up, in order, the step-up converter, the card supply, the data lines and the clock. From a fixed point onward it hands the card reset line to the host's reset request.

A session ends in one of three ways. The host can release the power command, the host can drop the run/sleep input, or a fault can occur. A fault is either a raised fault flag or the card being pulled out. The block then powers the contacts down in the reverse order on a fixed schedule. A fault also pulls an active-low interrupt. That interrupt stays low until the slot is idle, the host has released the power command, and a card is seated. Dropping the run/sleep input parks the block in a low-power state. Raising it again returns the block to idle only after a fixed wake delay.

Top module: `card_slot_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, every enable output, `card_rst` and `sleep_o` are 0 and `irq_n` is 1.
- R2: In idle, with `mode_run` high and no interrupt pending, a low `pwr_cmd_n` sampled on clock edge E0 starts activation, and `boost_en` is 1 after E0. This also applies when idle is reached from a wake with `pwr_cmd_n` already low.
- R3: `vcc_en` rises on edge E0+96 (1.5 T) of an activation.
- R4: `io_release` is 0 (data lines held low) until edge E0+256 (4 T), when it rises.
- R5: `clk_en` rises on the first edge from E0+256 onward at which `rst_req` is sampled high. If that has not happened by edge E0+448 (7 T), it rises there.
- R6: `card_rst` is 0 before edge E0+448. From that edge on, after each edge it equals the inverse of `rst_req` sampled on that edge.
- R7: For a deactivation starting at edge D0, `card_rst` is 0 after D0. `clk_en` falls at D0+32, `io_release` at D0+64, `vcc_en` at D0+96 and `boost_en` at D0+320. An output that was never on stays off.
- R8: During activation or an active session, any bit of `fault_flags` high, or `card_present` low, sampled on an edge drives `irq_n` low after that edge and starts deactivation there.
- R9: After a fault, `irq_n` stays low and activation stays locked out until an edge in idle samples `pwr_cmd_n` high and `card_present` high. `irq_n` is 1 after that edge.
- R10: `mode_run` low in idle moves the block to low power (`sleep_o` 1 after that edge). `mode_run` low in a session runs a full deactivation, and `sleep_o` rises at D0+320. No activation happens while in low power.
- R11: After `mode_run` is sampled high at edge W0 in low power, `sleep_o` stays 1 until edge W0+192 (96 slow output-clock periods). A low `mode_run` during that wait restarts it.
- R12: Fault flags and card absence seen outside a session leave `irq_n` high and all enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_cmd_n | input | 1 | Session request, active low |
| mode_run | input | 1 | High = normal operation, low = low-power |
| rst_req | input | 1 | Host reset request; gates the clock start, then drives card reset inverted |
| card_present | input | 1 | High while a card is seated |
| fault_flags | input | NFAULT | Overcurrent, supply drop, overheat flags, active high |
| boost_en | output | 1 | Step-up converter enable |
| vcc_en | output | 1 | Card supply enable |
| io_release | output | 1 | Data lines released (0 = forced low) |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset contact level |
| irq_n | output | 1 | Fault interrupt, active low |
| sleep_o | output | 1 | High in low-power state and during the wake delay |

## Verification
The hardest case to reach is the interplay between the reset-request window and the fixed step points. Clock start and card reset depend on the exact edge at which `rst_req` rises relative to E0+256 and E0+448. The stimulus sweeps that rise edge across and around both boundaries. Every output is compared on every cycle against a schedule computed arithmetically from the edge index. Aborts are injected at edges one before, on and one after each step point, to show that outputs which never came on stay off during the power-down. A wake with the power command already low shows that a second route into activation exists.

// File: rtl/card_slot_pkg.sv
package card_slot_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_ACT,
    ST_ACTIVE,
    ST_DEACT,
    ST_SLEEP,
    ST_WAKE
  } slot_state_t;

  // step counter counts half-T units
  localparam int STEP_W = 4;

  // power-up step points (half-T after start)
  localparam logic [STEP_W-1:0] UP_VCC  = STEP_W'(3);
  localparam logic [STEP_W-1:0] UP_IO   = STEP_W'(8);
  localparam logic [STEP_W-1:0] UP_LAST = STEP_W'(13);
  localparam logic [STEP_W-1:0] UP_ON   = STEP_W'(14);

  // power-down: counter loads DN_TOP and counts down to zero
  localparam logic [STEP_W-1:0] DN_TOP  = STEP_W'(10);
  localparam logic [STEP_W-1:0] DN_CLK  = STEP_W'(9);
  localparam logic [STEP_W-1:0] DN_IO   = STEP_W'(8);
  localparam logic [STEP_W-1:0] DN_VCC  = STEP_W'(7);

endpackage

// File: rtl/card_slot_halfstep.sv
module card_slot_halfstep #(
  parameter int HALF_T = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  localparam int PRE_W = $clog2(HALF_T) + 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(HALF_T - 1);

  logic [PRE_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R7: prescaler never leaves its half-step range
  p_pre_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/card_slot_wake.sv
module card_slot_wake #(
  parameter int WAKE_CYCLES = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int WK_W = $clog2(WAKE_CYCLES) + 1;
  localparam logic [WK_W-1:0] LAST = WK_W'(WAKE_CYCLES - 1);

  logic [WK_W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  // R11: wait counter stays parked at zero outside the wake wait
  p_wake_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (cnt == '0));

endmodule

// File: rtl/card_slot_fsm.sv
module card_slot_fsm
  import card_slot_pkg::*;
#(
  parameter int NFAULT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cmd_n,
  input  logic              mode_run,
  input  logic              rst_req,
  input  logic              card_present,
  input  logic [NFAULT-1:0] fault_flags,
  input  logic              tick,
  input  logic              wake_done,
  output logic              seq_clr,
  output logic              wake_run,
  output logic              boost_en,
  output logic              vcc_en,
  output logic              io_release,
  output logic              clk_en,
  output logic              card_rst,
  output logic              irq_n,
  output logic              sleep_o
);

  slot_state_t       st, st_n;
  logic [STEP_W-1:0] step, step_n;
  logic boost_r, vcc_r, io_r, clk_r, rst_r, irq_r, sleep_r;
  logic fault_now, in_sess, quit;

  assign fault_now = (|fault_flags) | ~card_present;
  assign in_sess   = (st == ST_ACT) || (st == ST_ACTIVE);
  assign quit      = pwr_cmd_n | ~mode_run | fault_now;
  assign wake_run  = (st == ST_WAKE);

  always_comb begin
    st_n    = st;
    step_n  = step;
    seq_clr = 1'b0;
    case (st)
      ST_OFF: st_n = ST_IDLE;
      ST_IDLE: begin
        if (!mode_run) st_n = ST_SLEEP;
        else if (!pwr_cmd_n && irq_r) begin
          st_n    = ST_ACT;
          step_n  = '0;
          seq_clr = 1'b1;
        end
      end
      ST_ACT, ST_ACTIVE: begin
        if (quit) begin
          st_n    = ST_DEACT;
          step_n  = DN_TOP;
          seq_clr = 1'b1;
        end else if (st == ST_ACT && tick) begin
          if (step == UP_LAST) begin
            st_n   = ST_ACTIVE;
            step_n = UP_ON;
          end else begin
            step_n = step + 1'b1;
          end
        end
      end
      ST_DEACT: begin
        if (tick) begin
          if (step == STEP_W'(1)) begin
            step_n = '0;
            st_n   = mode_run ? ST_IDLE : ST_SLEEP;
          end else begin
            step_n = step - 1'b1;
          end
        end
      end
      ST_SLEEP: if (mode_run) st_n = ST_WAKE;
      ST_WAKE: begin
        if (!mode_run) st_n = ST_SLEEP;
        else if (wake_done) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OFF;
      step    <= '0;
      boost_r <= 1'b0;
      vcc_r   <= 1'b0;
      io_r    <= 1'b0;
      clk_r   <= 1'b0;
      rst_r   <= 1'b0;
      irq_r   <= 1'b1;
      sleep_r <= 1'b0;
    end else begin
      st      <= st_n;
      step    <= step_n;
      boost_r <= (st_n == ST_ACT) || (st_n == ST_ACTIVE) || (st_n == ST_DEACT);
      vcc_r   <= (st_n == ST_ACT && step_n >= UP_VCC) || (st_n == ST_ACTIVE)
              || (st_n == ST_DEACT && vcc_r && step_n > DN_VCC);
      io_r    <= (st_n == ST_ACT && step_n >= UP_IO) || (st_n == ST_ACTIVE)
              || (st_n == ST_DEACT && io_r && step_n > DN_IO);
      clk_r   <= (st_n == ST_ACT && (clk_r || (step_n >= UP_IO && rst_req)))
              || (st_n == ST_ACTIVE)
              || (st_n == ST_DEACT && clk_r && step_n > DN_CLK);
      rst_r   <= (st_n == ST_ACTIVE) && !rst_req;
      sleep_r <= (st_n == ST_SLEEP) || (st_n == ST_WAKE);
      if (in_sess && fault_now) irq_r <= 1'b0;
      else if (st == ST_IDLE && pwr_cmd_n && card_present) irq_r <= 1'b1;
    end
  end

  assign boost_en   = boost_r;
  assign vcc_en     = vcc_r;
  assign io_release = io_r;
  assign clk_en     = clk_r;
  assign card_rst   = rst_r;
  assign irq_n      = irq_r;
  assign sleep_o    = sleep_r;

  // R3: card supply never on without the step-up converter
  p_vcc_needs_boost_r3: assert property (@(posedge clk) disable iff (rst)
    vcc_r |-> boost_r);
  // R4: data lines only released with card supply present
  p_io_needs_vcc_r4: assert property (@(posedge clk) disable iff (rst)
    io_r |-> vcc_r);
  // R6: card reset released only with clock and data lines up
  p_rst_needs_clk_r6: assert property (@(posedge clk) disable iff (rst)
    rst_r |-> (clk_r && io_r));
  // R7: nothing switches on while powering down
  p_deact_monotonic_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEACT) |-> (!$rose(vcc_r) && !$rose(io_r) && !$rose(clk_r) && !$rose(boost_r)));
  // R8: interrupt only asserted out of a session
  p_irq_from_session_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_r) |-> $past(in_sess));
  // R10: no activation out of low power
  p_no_act_asleep_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLEEP) |=> (st != ST_ACT));
  // R11: low-power indicator only drops at the end of the wake wait
  p_wake_exit_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_r) |-> $past(st == ST_WAKE));

endmodule

// File: rtl/card_slot_seq.sv
module card_slot_seq #(
  parameter int NFAULT      = 3,
  parameter int HALF_T      = 32,
  parameter int WAKE_CYCLES = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cmd_n,
  input  logic              mode_run,
  input  logic              rst_req,
  input  logic              card_present,
  input  logic [NFAULT-1:0] fault_flags,
  output logic              boost_en,
  output logic              vcc_en,
  output logic              io_release,
  output logic              clk_en,
  output logic              card_rst,
  output logic              irq_n,
  output logic              sleep_o
);

  logic tick, seq_clr, wake_run, wake_done;

  card_slot_halfstep #(.HALF_T(HALF_T)) u_half (
    .clk   (clk),
    .rst   (rst),
    .clear (seq_clr),
    .tick  (tick)
  );

  card_slot_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk  (clk),
    .rst  (rst),
    .run  (wake_run),
    .done (wake_done)
  );

  card_slot_fsm #(.NFAULT(NFAULT)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .pwr_cmd_n    (pwr_cmd_n),
    .mode_run     (mode_run),
    .rst_req      (rst_req),
    .card_present (card_present),
    .fault_flags  (fault_flags),
    .tick         (tick),
    .wake_done    (wake_done),
    .seq_clr      (seq_clr),
    .wake_run     (wake_run),
    .boost_en     (boost_en),
    .vcc_en       (vcc_en),
    .io_release   (io_release),
    .clk_en       (clk_en),
    .card_rst     (card_rst),
    .irq_n        (irq_n),
    .sleep_o      (sleep_o)
  );

endmodule

// File: tb/card_slot_seq_test.sv
module card_slot_seq_test;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rst, pwr_cmd_n, mode_run, rst_req, card_present;
  logic [NF-1:0] fault_flags;
  logic boost_en, vcc_en, io_release, clk_en, card_rst, irq_n, sleep_o;
  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  card_slot_seq #(.NFAULT(NF)) uut (
    .clk(clk), .rst(rst), .pwr_cmd_n(pwr_cmd_n), .mode_run(mode_run),
    .rst_req(rst_req), .card_present(card_present), .fault_flags(fault_flags),
    .boost_en(boost_en), .vcc_en(vcc_en), .io_release(io_release),
    .clk_en(clk_en), .card_rst(card_rst), .irq_n(irq_n), .sleep_o(sleep_o)
  );

  // order: boost vcc io clk rst irq_n sleep
  task automatic check(input string tag, input int idx, input logic [6:0] exp);
    logic [6:0] obs;
    obs = {boost_en, vcc_en, io_release, clk_en, card_rst, irq_n, sleep_o};
    vectors++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s at %0d: actual=%b expected=%b", tag, idx, obs, exp);
    end
  endtask

  task automatic step1();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [6:0] act_exp(input int n, input int r);
    logic c, rs;
    int start;
    start = (r > 256) ? r : 256;
    if (start > 448) start = 448;
    c  = (n >= start);
    rs = (n >= 448) && !(n >= r);
    return {1'b1, n >= 96, n >= 256, c, rs, 1'b1, 1'b0};
  endfunction

  // R2 R3 R4 R5 R6: per-cycle activation schedule
  task automatic run_act(input int r, input int upto, output logic [6:0] last);
    pwr_cmd_n = 1'b0;
    last = 7'b0000010;
    for (int n = 0; n < upto; n++) begin
      rst_req = (n >= r);
      step1();
      last = act_exp(n, r);
      check("R2 R3 R4 R5 R6", n, last);
    end
  endtask

  // cause: 0 power cmd high, 1 mode low, 2.. fault bit, 9 card removed
  task automatic run_deact(input logic [6:0] pre, input int cause);
    logic f;
    f = (cause >= 2);
    if (cause == 0) pwr_cmd_n = 1'b1;
    else if (cause == 1) mode_run = 1'b0;
    else if (cause == 9) card_present = 1'b0;
    else fault_flags[cause-2] = 1'b1;
    for (int m = 0; m < 330; m++) begin
      step1();
      check(f ? "R7 R8" : (cause == 1 ? "R7 R10" : "R7"), m,
            {pre[6] && m < 320, pre[5] && m < 96, pre[4] && m < 64,
             pre[3] && m < 32, 1'b0, !f, cause == 1 && m >= 320});
    end
  endtask

  task automatic hold_check(input string tag, input int cyc, input logic [6:0] exp);
    for (int i = 0; i < cyc; i++) begin
      step1();
      check(tag, i, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [6:0] last;
    int rlist[10];
    int alist[9];
    rlist = '{0, 100, 255, 256, 257, 300, 447, 448, 600, 100000};
    alist = '{1, 95, 96, 97, 255, 256, 257, 447, 448};
    rst = 1'b1; pwr_cmd_n = 1'b1; mode_run = 1'b1; rst_req = 1'b0;
    card_present = 1'b1; fault_flags = '0;
    repeat (4) step1();
    check("R1 in reset", 0, 7'b0000010);
    rst = 1'b0;
    step1();
    check("R1 after reset", 1, 7'b0000010);
    hold_check("R1 idle", 3, 7'b0000010);

    // full sessions, sweeping the reset-request rise edge
    foreach (rlist[i]) begin
      run_act(rlist[i], 520, last);
      run_deact(last, 0);
      hold_check("R7 back to idle", 5, 7'b0000010);
    end

    // aborts around each step point
    foreach (alist[i]) begin
      run_act(300, alist[i], last);
      run_deact(last, 0);
      hold_check("R7 abort idle", 5, 7'b0000010);
    end

    // faults: interrupt, lockout, release
    for (int b = 0; b < NF; b++) begin
      run_act(300, 500, last);
      run_deact(last, 2 + b);
      fault_flags = '0;
      hold_check("R9 lockout", 40, 7'b0000000);
      pwr_cmd_n = 1'b1;
      step1();
      check("R9 release", b, 7'b0000010);
    end
    run_act(300, 300, last);
    run_deact(last, 9);
    pwr_cmd_n = 1'b1;
    hold_check("R9 no card keeps irq low", 20, 7'b0000000);
    card_present = 1'b1;
    step1();
    check("R9 card back", 0, 7'b0000010);

    // mode low in session, sleep, wake with command still low
    run_act(300, 460, last);
    run_deact(last, 1);
    hold_check("R10 asleep no activation", 50, 7'b0000011);
    mode_run = 1'b1;
    for (int w = 0; w < 192; w++) begin
      step1();
      check("R11 wake wait", w, 7'b0000011);
    end
    step1();
    check("R11 wake done", 192, 7'b0000010);
    step1();
    check("R2 activation after wake", 193, 7'b1000010);
    run_deact(7'b1000010, 0);

    // idle to sleep, interrupted wake
    mode_run = 1'b0;
    step1();
    check("R10 idle to sleep", 0, 7'b0000011);
    pwr_cmd_n = 1'b0;
    hold_check("R10 sleep ignores command", 30, 7'b0000011);
    pwr_cmd_n = 1'b1;
    mode_run = 1'b1;
    hold_check("R11 partial wake", 100, 7'b0000011);
    mode_run = 1'b0;
    hold_check("R11 wake abandoned", 10, 7'b0000011);
    mode_run = 1'b1;
    for (int w = 0; w < 192; w++) begin
      step1();
      check("R11 restarted wait", w, 7'b0000011);
    end
    step1();
    check("R11 restarted done", 192, 7'b0000010);

    // faults outside a session
    fault_flags = '1;
    card_present = 1'b0;
    hold_check("R12 idle faults ignored", 20, 7'b0000010);
    fault_flags = '0;
    card_present = 1'b1;
    hold_check("R12 idle after", 3, 7'b0000010);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule